// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block takes 20-bit frames from a host over a slow three-wire link: a serial clock, a data line and a strobe. It writes each frame into one of four parallel registers, which hold a 12-bit reference divisor, a 14-bit transmit divisor, a 14-bit receive divisor and a 16-bit control word. The host shifts a frame in one bit per serial clock rising edge and then raises the strobe. The two bits sent last form a select code. That code picks which register takes the frame, and each register reads its own fields from the frame.

All three link inputs are brought into the system clock domain through multi-flop synchronisers, and their edges are found there, so the system clock has to run much faster than the serial clock. One shift register serves all four destinations. Every register write is marked on its own output by a single-cycle update pulse. A sticky flag records any reference frame that arrived with its reserved test bits not zero.

Top module: `serial_reg_loader`

## Requirements
- R1: After reset every register output, `alarm_sel_o` and `test_err_o` are 0, and no `upd_o` pulse appears until a strobe rising edge has been seen.
- R2: `sdata_i` is sampled at each rising edge of `sclk_i`. The bit sent first in a frame is frame position 0. Only the 20 bits sent most recently count, so extra leading bits have no effect.
- R3: The select code is {position 18, position 19}. Code 11 writes the reference register, 10 the transmit register, 01 the receive register and 00 the control register. The other three registers keep their values.
- R4: In a reference frame, positions 6..17 carry the divisor LSB first into `ref_div_o[0..11]`, position 5 goes to `alarm_sel_o`, positions 3..4 are test bits, and positions 0..2 are ignored.
- R5: In a transmit or receive frame, positions 4..17 carry the divisor LSB first into bits 0..13 of the output, and positions 0..3 are ignored.
- R6: In a control frame, positions 2..17 go to `ctrl_o[0..15]`, and positions 0..1 are ignored.
- R7: Each strobe rising edge produces exactly one single-cycle pulse on `upd_o[code]` (bit 3 reference, bit 2 transmit, bit 1 receive, bit 0 control). The pulse lands on the third system clock edge after the edge, in the same cycle as the register value changes. A strobe held high gives only one pulse.
- R8: A reference frame whose test bits are not zero is still written. It also sets `test_err_o`, which stays at 1 until reset.
- R9: Shifting bits without a strobe rising edge changes no output. A strobe given later writes the frame that was shifted in most recently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial bit clock, asynchronous |
| sdata_i | input | 1 | Serial data |
| sstb_i | input | 1 | Transfer strobe, active high |
| ref_div_o | output | 12 | Reference divisor |
| alarm_sel_o | output | 1 | Alarm select bit from the reference frame |
| tx_div_o | output | 14 | Transmit divisor |
| rx_div_o | output | 14 | Receive divisor |
| ctrl_o | output | 16 | Control word |
| upd_o | output | 4 | One-cycle write pulses, indexed by select code |
| test_err_o | output | 1 | Sticky flag for nonzero reference test bits |

## Verification
A corrupted shift register or synchroniser does not show on any output until the next strobe. At that point it appears as a wrong field value, or as the wrong register changing, three system clocks after the strobe rises. The bench therefore checks every register after every frame, and the checks include the registers that should have held their values. A misplaced select code or a swapped destination becomes visible at once as an unexpected change in a neighbour register, or as a miscount of update pulses. The sticky error flag is checked again after a clean frame, to catch state that is cleared too early.

// File: rtl/srl_pkg.sv
package srl_pkg;
   // destination select; the value doubles as the update-pulse index
   typedef enum logic [1:0] {
      SEL_CTRL = 2'b00,
      SEL_RX   = 2'b01,
      SEL_TX   = 2'b10,
      SEL_REF  = 2'b11
   } sel_e;
endpackage

// File: rtl/srl_sync.sv
module srl_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("srl_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= '0;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[s] <= '0;
            else        st[s] <= st[s-1];
         end
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/srl_shifter.sv
module srl_shifter #(
   parameter int KEEP_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sdata_s,
   input  logic              stb_s,
   output logic [KEEP_W-1:0] win,
   output logic              stb_rise
);
   if (KEEP_W < 3) begin : g_bad_keep
      $error("srl_shifter: KEEP_W too small");
   end

   logic sclk_d, stb_d, clk_rise;

   assign clk_rise = sclk_s & ~sclk_d;
   assign stb_rise = stb_s & ~stb_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         stb_d  <= 1'b0;
         win    <= '0;
      end else begin
         sclk_d <= sclk_s;
         stb_d  <= stb_s;
         // newest bit enters at the top, so the first-sent bit ends lowest
         if (clk_rise) win <= {sdata_s, win[KEEP_W-1:1]};
      end
   end

   AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_rise |=> $stable(win)); // R2
endmodule

// File: rtl/srl_router.sv
module srl_router
   import srl_pkg::*;
#(
   parameter int FRAME_W  = 20,
   parameter int REF_W    = 12,
   parameter int DIV_W    = 14,
   parameter int CTRL_W   = 16,
   parameter int TEST_W   = 2,
   parameter int KEEP_LSB = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [FRAME_W-KEEP_LSB-1:0]   win,
   input  logic                          stb_rise,
   output logic [REF_W-1:0]              ref_q,
   output logic                          bc_q,
   output logic [DIV_W-1:0]              tx_q,
   output logic [DIV_W-1:0]              rx_q,
   output logic [CTRL_W-1:0]             ctrl_q,
   output logic [3:0]                    upd,
   output logic                          err
);
   // positions relative to the kept window
   localparam int CODE_POS = FRAME_W - 2 - KEEP_LSB;
   localparam int REF_LSB  = CODE_POS - REF_W;
   localparam int BC_POS   = REF_LSB - 1;
   localparam int TEST_LSB = BC_POS - TEST_W;
   localparam int DIV_LSB  = CODE_POS - DIV_W;
   localparam int CTRL_LSB = CODE_POS - CTRL_W;

   if (TEST_LSB < 0 || DIV_LSB < 0 || CTRL_LSB < 0) begin : g_bad_layout
      $error("srl_router: fields do not fit in the frame");
   end

   sel_e       code;
   logic [3:0] hit;
   logic [DIV_W-1:0] div_q [2];

   assign code = sel_e'({win[CODE_POS], win[CODE_POS+1]});
   assign hit  = stb_rise ? (4'b0001 << code) : 4'b0000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q  <= '0;
         bc_q   <= 1'b0;
         ctrl_q <= '0;
         upd    <= '0;
         err    <= 1'b0;
      end else begin
         upd <= hit;
         if (hit[SEL_REF]) begin
            ref_q <= win[REF_LSB +: REF_W];
            bc_q  <= win[BC_POS];
            if (|win[TEST_LSB +: TEST_W]) err <= 1'b1;
         end
         if (hit[SEL_CTRL]) ctrl_q <= win[CTRL_LSB +: CTRL_W];
      end
   end

   // the two divisor registers share one layout; index g+1 is their code
   for (genvar g = 0; g < 2; g++) begin : g_div
      localparam int CODE_IDX = g + 1;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              div_q[g] <= '0;
         else if (hit[CODE_IDX])  div_q[g] <= win[DIV_LSB +: DIV_W];
      end
   end

   assign rx_q = div_q[0];
   assign tx_q = div_q[1];

   AST_ONE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(upd)); // R7
   AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (|upd) |=> (upd == 4'b0000)); // R7
   AST_UPD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (|upd) |-> $past(stb_rise)); // R9
   AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_q != $past(ref_q)) |-> upd[SEL_REF]); // R3
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q != $past(ctrl_q)) |-> upd[SEL_CTRL]); // R3
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err); // R8
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader #(
   parameter int FRAME_W     = 20,
   parameter int REF_W       = 12,
   parameter int DIV_W       = 14,
   parameter int CTRL_W      = 16,
   parameter int TEST_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sclk_i,
   input  logic              sdata_i,
   input  logic              sstb_i,
   output logic [REF_W-1:0]  ref_div_o,
   output logic              alarm_sel_o,
   output logic [DIV_W-1:0]  tx_div_o,
   output logic [DIV_W-1:0]  rx_div_o,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic [3:0]        upd_o,
   output logic              test_err_o
);
   localparam int CODE_POS = FRAME_W - 2;
   localparam int TEST_LSB = CODE_POS - REF_W - 1 - TEST_W;
   localparam int DIV_LSB  = CODE_POS - DIV_W;
   localparam int CTRL_LSB = CODE_POS - CTRL_W;
   localparam int MIN_A    = (TEST_LSB < DIV_LSB) ? TEST_LSB : DIV_LSB;
   // oldest positions that no register reads are not stored
   localparam int KEEP_LSB = (MIN_A < CTRL_LSB) ? MIN_A : CTRL_LSB;
   localparam int KEEP_W   = FRAME_W - KEEP_LSB;

   if (KEEP_LSB < 0) begin : g_bad_frame
      $error("serial_reg_loader: FRAME_W too small for the field widths");
   end

   logic [2:0]        sync_q;
   logic [KEEP_W-1:0] win;
   logic              stb_rise;

   srl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_i),
      .rst_n (rst_ni),
      .d     ({sstb_i, sdata_i, sclk_i}),
      .q     (sync_q)
   );

   srl_shifter #(.KEEP_W(KEEP_W)) u_shift (
      .clk      (clk_i),
      .rst_n    (rst_ni),
      .sclk_s   (sync_q[0]),
      .sdata_s  (sync_q[1]),
      .stb_s    (sync_q[2]),
      .win      (win),
      .stb_rise (stb_rise)
   );

   srl_router #(
      .FRAME_W  (FRAME_W),
      .REF_W    (REF_W),
      .DIV_W    (DIV_W),
      .CTRL_W   (CTRL_W),
      .TEST_W   (TEST_W),
      .KEEP_LSB (KEEP_LSB)
   ) u_route (
      .clk      (clk_i),
      .rst_n    (rst_ni),
      .win      (win),
      .stb_rise (stb_rise),
      .ref_q    (ref_div_o),
      .bc_q     (alarm_sel_o),
      .tx_q     (tx_div_o),
      .rx_q     (rx_div_o),
      .ctrl_q   (ctrl_o),
      .upd      (upd_o),
      .err      (test_err_o)
   );
endmodule

// File: tb/tb_serial_reg_loader.sv
`timescale 1ns/1ps
module tb_serial_reg_loader;
   logic clk = 1'b0, rst_n = 1'b0;
   logic sclk = 1'b0, sdata = 1'b0, sstb = 1'b0;
   logic [11:0] ref_div_o;
   logic        alarm_sel_o;
   logic [13:0] tx_div_o, rx_div_o;
   logic [15:0] ctrl_o;
   logic [3:0]  upd_o;
   logic        test_err_o;

   serial_reg_loader dut (
      .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sstb_i(sstb),
      .ref_div_o(ref_div_o), .alarm_sel_o(alarm_sel_o), .tx_div_o(tx_div_o),
      .rx_div_o(rx_div_o), .ctrl_o(ctrl_o), .upd_o(upd_o), .test_err_o(test_err_o)
   );

   always #4 clk = ~clk;   // 125 MHz

   int errors = 0, checks = 0;
   int ucnt [4] = '{0, 0, 0, 0};
   int ecnt [4] = '{0, 0, 0, 0};

   always @(posedge clk) begin
      for (int i = 0; i < 4; i++) if (upd_o[i] === 1'b1) ucnt[i]++;
   end

   // bench-side model of the register file
   logic [11:0] ref_m = '0;
   logic        bc_m = 1'b0, err_m = 1'b0;
   logic [13:0] tx_m = '0, rx_m = '0;
   logic [15:0] ctrl_m = '0;

   typedef struct packed {
      logic [1:0]  code;
      logic [15:0] val;
      logic        bc;
      logic [3:0]  junk;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{2'b11, 16'd2048,  1'b1, 4'hA},
      '{2'b01, 16'd7183,  1'b0, 4'h5},
      '{2'b10, 16'd9934,  1'b0, 4'hF},
      '{2'b00, 16'hA5C3,  1'b0, 4'h3},
      '{2'b11, 16'd4095,  1'b0, 4'h7},
      '{2'b10, 16'd5,     1'b0, 4'h0},
      '{2'b01, 16'd16383, 1'b0, 4'h9},
      '{2'b00, 16'h0001,  1'b0, 4'hC}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [19:0] build(input logic [1:0] code, input logic [15:0] val,
                                         input logic bc, input logic [1:0] test,
                                         input logic [3:0] junk);
      logic [19:0] f;
      f = '0;
      f[18] = code[1];
      f[19] = code[0];
      case (code)
         2'b11: begin f[17:6] = val[11:0]; f[5] = bc; f[4:3] = test; f[2:0] = junk[2:0]; end
         2'b00: begin f[17:2] = val; f[1:0] = junk[1:0]; end
         default: begin f[17:4] = val[13:0]; f[3:0] = junk; end
      endcase
      return f;
   endfunction

   task automatic model(input logic [19:0] f);
      logic [1:0] c;
      c = {f[18], f[19]};
      case (c)
         2'b11: begin ref_m = f[17:6]; bc_m = f[5]; if (f[4:3] != 2'b00) err_m = 1'b1; end
         2'b10: tx_m = f[17:4];
         2'b01: rx_m = f[17:4];
         default: ctrl_m = f[17:2];
      endcase
      ecnt[c]++;
   endtask

   task automatic shift_bit(input logic b);
      @(negedge clk) sdata = b;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (5) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_stb(input int width);
      repeat (3) @(negedge clk);
      sstb = 1'b1;
      repeat (width) @(negedge clk);
      sstb = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic shift_frame(input logic [19:0] f);
      for (int k = 0; k < 20; k++) shift_bit(f[k]);
   endtask

   task automatic check_all(input string tag);
      chk({tag, " R3/R4 ref_div"}, 32'(ref_div_o), 32'(ref_m));
      chk({tag, " R3/R4 alarm_sel"}, 32'(alarm_sel_o), 32'(bc_m));
      chk({tag, " R3/R5 tx_div"}, 32'(tx_div_o), 32'(tx_m));
      chk({tag, " R3/R5 rx_div"}, 32'(rx_div_o), 32'(rx_m));
      chk({tag, " R3/R6 ctrl"}, 32'(ctrl_o), 32'(ctrl_m));
      for (int i = 0; i < 4; i++) chk({tag, " R7 update count"}, 32'(ucnt[i]), 32'(ecnt[i]));
      chk({tag, " R8 test_err"}, 32'(test_err_o), 32'(err_m));
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [19:0] f;
      // R1: reset state
      repeat (5) @(negedge clk);
      chk("R1 ref during reset", 32'(ref_div_o), 0);
      chk("R1 upd during reset", 32'(upd_o), 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      check_all("R1 after reset");

      // table walk
      for (int v = 0; v < NV; v++) begin
         f = build(VECS[v].code, VECS[v].val, VECS[v].bc, 2'b00, VECS[v].junk);
         shift_frame(f);
         pulse_stb(6);
         model(f);
         check_all($sformatf("vec%0d", v));
      end

      // R2: five leading garbage bits, then a full receive frame
      for (int k = 0; k < 5; k++) shift_bit(k[0]);
      f = build(2'b01, 16'd7255, 1'b0, 2'b00, 4'h6);
      shift_frame(f);
      pulse_stb(6);
      model(f);
      check_all("R2 leading bits");

      // R9: shift a transmit frame without strobe, nothing moves
      f = build(2'b10, 16'd1234, 1'b0, 2'b00, 4'h1);
      shift_frame(f);
      repeat (10) @(negedge clk);
      check_all("R9 no strobe");
      // R9: a later strobe writes the frame just shifted; long strobe gives one pulse (R7)
      pulse_stb(40);
      model(f);
      check_all("R9 late strobe");

      // R8: nonzero test bits still write the reference register and set the flag
      f = build(2'b11, 16'd777, 1'b1, 2'b01, 4'h2);
      shift_frame(f);
      pulse_stb(6);
      model(f);
      chk("R8 flag set", 32'(test_err_o), 1);
      check_all("R8 bad test bits");
      f = build(2'b11, 16'd5, 1'b0, 2'b00, 4'h0);
      shift_frame(f);
      pulse_stb(6);
      model(f);
      chk("R8 flag sticky", 32'(test_err_o), 1);
      check_all("R8 clean frame");

      // R1: reset again clears everything
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 ref cleared", 32'(ref_div_o), 0);
      chk("R1 tx cleared", 32'(tx_div_o), 0);
      chk("R1 err cleared", 32'(test_err_o), 0);
      finish_run();
   end
endmodule